// File: doc/BRIEF.md
# Standby power mode controller

This controller moves a small chip into one of three low-power depths and brings it back to normal operation. Software first selects a depth through an 8-bit mode register, which can be written as a whole byte or one bit at a time. It then arms standby and raises a trigger. While the chip is in a depth, the controller drives per-domain clock enables that keep only the sources that depth needs.

When a release event arrives, the controller returns to normal operation. It does so at once from the shallowest depth. From the two deeper depths it first passes through a wake-wait state, whose length is loaded from a programmable stabilization count. The whole controller runs on an always-on ring oscillator clock. The main oscillator, PLL and flash are represented only by their enable bits.

States are `ST_NORMAL`, `ST_IDLE1` (shallow idle), `ST_IDLE2` (deep idle), `ST_STOP` and `ST_WAKE_WAIT`. The transitions are:
- NORMAL→IDLE1, NORMAL→IDLE2 and NORMAL→STOP, taken on an armed trigger with mode 00, 01 or 10 respectively.
- IDLE1→NORMAL on release.
- IDLE2→WAKE_WAIT and STOP→WAKE_WAIT on release.
- WAKE_WAIT→NORMAL when the wait counter is zero.
- An armed trigger with mode 11 leaves the controller in NORMAL and raises a sticky error.

Top module: `stby_ctrl`

## Requirements
- R1: After reset the mode register reads 0x00, `ready_o`=1, `clk_en_o`=4'b1111, `arm_o`=0 and `mode_err_o`=0. The clock-enable bits are [3] main oscillator, [2] PLL, [1] flash and [0] core.
- R2: A byte write (`reg_wr_bit`=0) loads `reg_wdata[1:0]` into the mode field. Bits 7..2 always read as zero, whatever value was written to them.
- R3: A single-bit write (`reg_wr_bit`=1) sets bit `reg_bit_sel` to `reg_wdata[0]` when the index is 0 or 1. For an index of 2..7 the register is left unchanged.
- R4: A trigger while `arm_o`=0 is ignored. The controller stays in NORMAL with `ready_o`=1.
- R5: An armed trigger with mode 00 enters shallow idle on the next edge. There `clk_en_o`=4'b1110 and `ready_o`=0.
- R6: An armed trigger with mode 01 enters deep idle, with `clk_en_o`=4'b1010 (PLL off).
- R7: An armed trigger with mode 10 enters stop, with `clk_en_o`=4'b0000.
- R8: An armed trigger with mode 11 keeps NORMAL and sets `mode_err_o`, which then stays set until reset.
- R9: A release in shallow idle returns to NORMAL on the next edge, with no wait.
- R10: A release in deep idle or stop enters wake-wait, with `clk_en_o`=4'b1110 and `ready_o`=0, for `stab_count`+1 cycles. It then returns to NORMAL.
- R11: A release during wake-wait does not reload or extend the wait. A trigger outside NORMAL is ignored.
- R12: `arm_o` clears on every return to NORMAL. `arm_set` has effect only in NORMAL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on ring oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Mode register write strobe |
| reg_wr_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| reg_bit_sel | input | 3 | Bit index for a single-bit write |
| reg_wdata | input | 8 | Write data (bit 0 carries the value for a single-bit write) |
| reg_rdata | output | 8 | Mode register read value |
| arm_set | input | 1 | Sets the standby enable bit |
| arm_o | output | 1 | Standby enable bit |
| stby_req | input | 1 | Standby trigger |
| wake_evt | input | 1 | Release event |
| stab_count | input | 16 | Wake-wait length, in clock cycles minus one |
| ready_o | output | 1 | High in normal operation |
| clk_en_o | output | 4 | Domain enables: osc, PLL, flash, core |
| mode_err_o | output | 1 | Sticky flag for a prohibited mode code |

## Verification
Register writes, arming, triggers and releases each take effect on the edge that samples them. The outputs are decoded directly from the state, so every result is visible in the same cycle as that edge. The only delayed result is the return from wake-wait, which is due `stab_count`+1 cycles after the release edge. The bench drives its inputs just after a rising edge and advances a behavioural model on that same edge. It compares every output at the following falling edge, so each expected value, including the end of the wait window, is checked in the exact cycle it is due.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL,
        ST_IDLE1,
        ST_IDLE2,
        ST_STOP,
        ST_WAKE_WAIT
    } stby_state_e;

    localparam logic [1:0] MODE_IDLE1 = 2'b00;
    localparam logic [1:0] MODE_IDLE2 = 2'b01;
    localparam logic [1:0] MODE_STOP  = 2'b10;
    localparam logic [1:0] MODE_BAD   = 2'b11;

    localparam int CE_CORE  = 0;
    localparam int CE_FLASH = 1;
    localparam int CE_PLL   = 2;
    localparam int CE_OSC   = 3;
    localparam int CE_W     = 4;

endpackage

// File: rtl/stby_modereg.sv
module stby_modereg #(
    parameter int REG_W   = 8,
    parameter int FIELD_W = 2,
    localparam int SEL_W  = $clog2(REG_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_bit,
    input  logic [SEL_W-1:0]   bit_sel,
    input  logic [REG_W-1:0]   wdata,
    output logic [FIELD_W-1:0] mode_o,
    output logic [REG_W-1:0]   rdata_o
);

    logic [FIELD_W-1:0] field_q;

    for (genvar i = 0; i < FIELD_W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                field_q[i] <= 1'b0;
            end else if (wr_en) begin
                if (!wr_bit) begin
                    field_q[i] <= wdata[i];
                end else if (bit_sel == SEL_W'(i)) begin
                    field_q[i] <= wdata[0];
                end
            end
        end
    end

    assign mode_o  = field_q;
    assign rdata_o = {{(REG_W-FIELD_W){1'b0}}, field_q};

endmodule

// File: rtl/stby_wake_timer.sv
module stby_wake_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REG_W = 8,
    localparam int SEL_W = $clog2(REG_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr_en,
    input  logic             reg_wr_bit,
    input  logic [SEL_W-1:0] reg_bit_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             arm_set,
    output logic             arm_o,
    input  logic             stby_req,
    input  logic             wake_evt,
    input  logic [CNT_W-1:0] stab_count,
    output logic             ready_o,
    output logic [CE_W-1:0]  clk_en_o,
    output logic             mode_err_o
);

    stby_state_e st_q, st_nxt;
    logic [1:0]  mode;
    logic        arm_q, err_q;
    logic        err_set, arm_clr, tmr_load, tmr_dec, tmr_zero;

    stby_modereg #(.REG_W(REG_W), .FIELD_W(2)) u_modereg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_bit  (reg_wr_bit),
        .bit_sel (reg_bit_sel),
        .wdata   (reg_wdata),
        .mode_o  (mode),
        .rdata_o (reg_rdata)
    );

    stby_wake_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (stab_count),
        .dec      (tmr_dec),
        .zero_o   (tmr_zero)
    );

    // next-state logic
    always_comb begin
        st_nxt   = st_q;
        err_set  = 1'b0;
        tmr_load = 1'b0;
        unique case (st_q)
            ST_NORMAL: begin
                if (stby_req && arm_q) begin
                    unique case (mode)
                        MODE_IDLE1: st_nxt = ST_IDLE1;
                        MODE_IDLE2: st_nxt = ST_IDLE2;
                        MODE_STOP:  st_nxt = ST_STOP;
                        default:    err_set = 1'b1;
                    endcase
                end
            end
            ST_IDLE1: begin
                if (wake_evt) st_nxt = ST_NORMAL;
            end
            ST_IDLE2, ST_STOP: begin
                if (wake_evt) begin
                    st_nxt   = ST_WAKE_WAIT;
                    tmr_load = 1'b1;
                end
            end
            ST_WAKE_WAIT: begin
                if (tmr_zero) st_nxt = ST_NORMAL;
            end
            default: st_nxt = ST_NORMAL;
        endcase
    end

    assign tmr_dec = (st_q == ST_WAKE_WAIT) && !tmr_zero;
    assign arm_clr = (st_nxt == ST_NORMAL) && (st_q != ST_NORMAL);

    // state register and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_NORMAL;
            arm_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (arm_clr) begin
                arm_q <= 1'b0;
            end else if (arm_set && st_q == ST_NORMAL) begin
                arm_q <= 1'b1;
            end
            if (err_set) err_q <= 1'b1;
        end
    end

    // outputs decoded from state
    always_comb begin
        clk_en_o = '0;
        ready_o  = 1'b0;
        unique case (st_q)
            ST_NORMAL: begin
                clk_en_o = '1;
                ready_o  = 1'b1;
            end
            ST_IDLE1, ST_WAKE_WAIT: begin
                clk_en_o[CE_OSC]   = 1'b1;
                clk_en_o[CE_PLL]   = 1'b1;
                clk_en_o[CE_FLASH] = 1'b1;
            end
            ST_IDLE2: begin
                clk_en_o[CE_OSC]   = 1'b1;
                clk_en_o[CE_FLASH] = 1'b1;
            end
            ST_STOP: clk_en_o = '0;
            default: clk_en_o = '0;
        endcase
    end

    assign arm_o      = arm_q;
    assign mode_err_o = err_q;

endmodule

// File: rtl/stby_ctrl_chk.sv
module stby_ctrl_chk
    import stby_pkg::*;
#(
    parameter int REG_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stby_req,
    input logic              wake_evt,
    input logic              arm_o,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              ready_o,
    input logic [CE_W-1:0]   clk_en_o,
    input logic              mode_err_o,
    input stby_state_e       st_q
);

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:2] == '0);

    p_noarm_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_NORMAL && stby_req && !arm_o) |=> ready_o);

    p_stop_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_NORMAL && stby_req && arm_o && reg_rdata[1:0] == MODE_STOP)
        |=> clk_en_o == '0);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err_o |=> mode_err_o);

    p_idle1_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE1 && wake_evt) |=> ready_o);

    p_ready_full_clocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> clk_en_o == '1);

    p_no_trig_outside_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE2 && !wake_evt) |=> st_q == ST_IDLE2);

    p_arm_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> !arm_o);

endmodule

bind stby_ctrl stby_ctrl_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stby_req   (stby_req),
    .wake_evt   (wake_evt),
    .arm_o      (arm_o),
    .reg_rdata  (reg_rdata),
    .ready_o    (ready_o),
    .clk_en_o   (clk_en_o),
    .mode_err_o (mode_err_o),
    .st_q       (st_q)
);

// File: tb/tb_stby_ctrl.sv
module tb_stby_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_wr_bit = 1'b0;
    logic [2:0]  reg_bit_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        arm_set = 1'b0, arm_o;
    logic        stby_req = 1'b0, wake_evt = 1'b0;
    logic [15:0] stab_count = '0;
    logic        ready_o, mode_err_o;
    logic [3:0]  clk_en_o;

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    started = 0;

    always #2 clk = ~clk;

    stby_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_bit(reg_wr_bit),
        .reg_bit_sel(reg_bit_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .arm_set(arm_set), .arm_o(arm_o), .stby_req(stby_req), .wake_evt(wake_evt),
        .stab_count(stab_count), .ready_o(ready_o), .clk_en_o(clk_en_o),
        .mode_err_o(mode_err_o)
    );

    // behavioural reference: 0 normal, 1 shallow, 2 deep, 3 stop, 4 wait
    logic [1:0] m_mode;
    int         m_state, m_cnt;
    bit         m_arm, m_err;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_state = 0; m_cnt = 0; m_arm = 0; m_err = 0;
        end else begin
            int o_state; bit o_arm; logic [1:0] o_mode;
            o_state = m_state; o_arm = m_arm; o_mode = m_mode;
            if (reg_wr_en) begin
                if (!reg_wr_bit) m_mode = reg_wdata[1:0];
                else if (reg_bit_sel < 2) m_mode[reg_bit_sel[0]] = reg_wdata[0];
            end
            if (arm_set && o_state == 0) m_arm = 1;
            case (o_state)
                0: if (stby_req && o_arm) begin
                       if (o_mode == 3) m_err = 1;
                       else m_state = int'(o_mode) + 1;
                   end
                1: if (wake_evt) m_state = 0;
                2, 3: if (wake_evt) begin m_state = 4; m_cnt = int'(stab_count); end
                default: if (m_cnt == 0) m_state = 0; else m_cnt--;
            endcase
            if (m_state == 0 && o_state != 0) m_arm = 0;
        end
        started = 1;
    end

    function automatic logic [3:0] exp_ce(int s);
        case (s)
            0: return 4'b1111;
            1, 4: return 4'b1110;
            2: return 4'b1010;
            default: return 4'b0000;
        endcase
    endfunction

    task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (started) begin
        chk("rdata", 16'(reg_rdata), {14'd0, m_mode});
        chk("ready", 16'(ready_o), 16'(m_state == 0));
        chk("clk_en", 16'(clk_en_o), 16'(exp_ce(m_state)));
        chk("arm", 16'(arm_o), 16'(m_arm));
        chk("err", 16'(mode_err_o), 16'(m_err));
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr_byte(logic [7:0] d);
        reg_wr_en = 1; reg_wr_bit = 0; reg_wdata = d; tick(); reg_wr_en = 0;
    endtask

    task automatic wr_bit(logic [2:0] s, logic v);
        reg_wr_en = 1; reg_wr_bit = 1; reg_bit_sel = s; reg_wdata = {7'd0, v};
        tick(); reg_wr_en = 0; reg_wr_bit = 0;
    endtask

    task automatic pulse_arm();  arm_set = 1;  tick(); arm_set = 0;  endtask
    task automatic pulse_trig(); stby_req = 1; tick(); stby_req = 0; endtask
    task automatic pulse_wake(); wake_evt = 1; tick(); wake_evt = 0; endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1; tick(2);                       // R1 reset values
        cur_req = "R2"; wr_byte(8'hFF); tick();   // reads 0x03
        cur_req = "R3"; wr_bit(3'd1, 1'b0); wr_bit(3'd5, 1'b1); wr_bit(3'd7, 1'b0); tick();
        cur_req = "R4"; wr_byte(8'h00); pulse_trig(); tick(2);
        cur_req = "R5"; pulse_arm(); pulse_trig(); tick(3);
        cur_req = "R12"; pulse_arm(); tick();     // arm ignored outside normal
        cur_req = "R9"; pulse_wake(); tick(2);
        cur_req = "R6"; wr_bit(3'd0, 1'b1); stab_count = 16'd5; pulse_arm(); pulse_trig(); tick(2);
        cur_req = "R11"; pulse_trig(); tick();
        cur_req = "R10"; pulse_wake(); tick(2);
        cur_req = "R11"; pulse_wake(); tick(6);
        cur_req = "R7"; wr_byte(8'h02); stab_count = 16'd0; pulse_arm(); pulse_trig(); tick(3);
        cur_req = "R10"; pulse_wake(); tick(3);
        cur_req = "R8"; wr_byte(8'h03); pulse_arm(); pulse_trig(); tick(2);
        wr_byte(8'h00); pulse_trig(); tick(3);
        cur_req = "R12"; pulse_wake(); tick(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule